// File: doc/BRIEF.md
# Display Clock Prescaler with Fine Divider

This block produces the timing strobe for a segment-display controller. One of two clocks drives it: the internal system clock or a clock from an external oscillator pin, chosen by one select bit. On the chosen clock a 12-bit counter runs, and a 3-bit coarse code picks a power-of-two tap from it. The tap set has gaps: 16, 64, 128, 256, 512, 1024, 2048 and 4096.

A second stage counts tap events and divides them again by an integer from 1 to 8, set by a 3-bit fine code. The result is a one-cycle strobe. The display timing logic downstream uses it as its clock enable. The whole period is the coarse ratio times (fine code + 1), counted in cycles of the chosen clock.

New coarse and fine codes are taken in only when a strobe fires, and also while reset is held. Both counters restart at that point, so no period is ever cut short. The design treats a change of clock source as a change to be made under reset. It does not try to switch between the clocks without glitches.

Top module: `dclk_prescaler`

## Requirements
- R1: With `src_sel` = 0 the block counts rising edges of `clk_sys`; with `src_sel` = 1 it counts rising edges of `clk_ext`. The select is changed only while `rst` is high.
- R2: Coarse code values 0,1,2,3,4,5,6,7 give coarse ratios of 16, 64, 128, 256, 512, 1024, 2048 and 4096 respectively.
- R3: Fine code value f (0 to 7) divides the coarse tap rate by f+1. The strobe period is coarse ratio × (f+1) selected-clock cycles.
- R4: `tick_o` is high for exactly one selected-clock cycle per period.
- R5: After `rst` is released, `tick_o` first reads high after the P-th rising edge of the selected clock. P is the period from R3, using the codes present on the last edge with `rst` high. Later strobes follow every P edges.
- R6: A change to `coarse_sel` or `fine_sel` in the middle of a period does not alter that period. The codes present on the edge that raises `tick_o` set the length of the next period.
- R7: While `rst` is high on a rising edge, `tick_o` is low after that edge. A reset in the middle of a period restarts counting, so the next strobe comes a full P edges after release.
- R8: The largest setting, coarse code 7 with fine code 7, gives a period of 32768 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Internal system clock |
| clk_ext | input | 1 | Clock from the external oscillator pin |
| rst | input | 1 | Synchronous active-high reset, sampled on the selected clock |
| src_sel | input | 1 | Clock source select: 0 = system clock, 1 = external clock |
| coarse_sel | input | 3 | Coarse ratio code (R2) |
| fine_sel | input | 3 | Fine divide code (R3) |
| tick_o | output | 1 | Registered one-cycle strobe at the prescaled rate |

## Verification
The bench measures the first period after reset and the period after it, for a spread of coarse and fine codes. That includes the smallest ratio and the full 32768 setting. A wrong tap position, or a fine divider off by one, shows up as a period that differs from ratio × (f+1). A counter that is too narrow breaks the longest period. The bench changes the codes mid-period and checks that the current period keeps its old length and the next one takes the new length. A design that applied codes at once would give a shortened or mixed period. The bench also resets in the middle of a count, where a missing counter clear gives an early strobe. It runs one case on the external clock, where counting the wrong clock gives a period off by the clock ratio.

// File: rtl/dpre_pkg.sv
package dpre_pkg;

  // log2 of the coarse ratio for a given code: code 0 -> base, then base+2 upward
  function automatic int tap_log(input int code, input int base_log);
    if (code == 0) tap_log = base_log;
    else           tap_log = base_log + 1 + code;
  endfunction

endpackage

// File: rtl/dpre_clk_mux.sv
module dpre_clk_mux (
  input  logic sel,
  input  logic clk_a,
  input  logic clk_b,
  output logic clk_o
);

  // source change is only made under reset; no glitch protection here
  assign clk_o = sel ? clk_b : clk_a;

endmodule

// File: rtl/dpre_coarse.sv
module dpre_coarse #(
  parameter int PS_W     = 12,
  parameter int CSEL_W   = 3,
  parameter int TAP0_LOG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [CSEL_W-1:0] code,
  output logic              tap_o
);

  localparam int NTAP = 2 ** CSEL_W;

  logic [PS_W-1:0] cnt;
  logic [NTAP-1:0] taps;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // each tap fires on the last count before its low bits wrap to zero
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int LG = dpre_pkg::tap_log(g, TAP0_LOG);
    assign taps[g] = &cnt[LG-1:0];
  end

  assign tap_o = taps[code];

endmodule

// File: rtl/dpre_fine.sv
module dpre_fine #(
  parameter int FSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tap_i,
  input  logic [FSEL_W-1:0] limit,
  output logic              fire_o
);

  logic [FSEL_W-1:0] fcnt;

  assign fire_o = tap_i && (fcnt == limit);

  always_ff @(posedge clk) begin
    if (rst || fire_o) fcnt <= '0;
    else if (tap_i)    fcnt <= fcnt + 1'b1;
  end

endmodule

// File: rtl/dclk_prescaler.sv
module dclk_prescaler #(
  parameter int PS_W     = 12,
  parameter int CSEL_W   = 3,
  parameter int FSEL_W   = 3,
  parameter int TAP0_LOG = 4
) (
  input  logic              clk_sys,
  input  logic              clk_ext,
  input  logic              rst,
  input  logic              src_sel,
  input  logic [CSEL_W-1:0] coarse_sel,
  input  logic [FSEL_W-1:0] fine_sel,
  output logic              tick_o
);

  logic              clk_dsp;
  logic [CSEL_W-1:0] coarse_act;
  logic [FSEL_W-1:0] fine_act;
  logic              tap;
  logic              fire;

  dpre_clk_mux u_mux (
    .sel   (src_sel),
    .clk_a (clk_sys),
    .clk_b (clk_ext),
    .clk_o (clk_dsp)
  );

  // codes are captured under reset and at every strobe only
  always_ff @(posedge clk_dsp) begin
    if (rst || fire) begin
      coarse_act <= coarse_sel;
      fine_act   <= fine_sel;
    end
  end

  dpre_coarse #(
    .PS_W     (PS_W),
    .CSEL_W   (CSEL_W),
    .TAP0_LOG (TAP0_LOG)
  ) u_coarse (
    .clk   (clk_dsp),
    .rst   (rst),
    .clr   (fire),
    .code  (coarse_act),
    .tap_o (tap)
  );

  dpre_fine #(
    .FSEL_W (FSEL_W)
  ) u_fine (
    .clk    (clk_dsp),
    .rst    (rst),
    .tap_i  (tap),
    .limit  (fine_act),
    .fire_o (fire)
  );

  always_ff @(posedge clk_dsp) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= fire;
  end

endmodule

// File: rtl/dpre_chk.sv
module dpre_chk #(
  parameter int CSEL_W = 3,
  parameter int FSEL_W = 3,
  parameter int CNT_W  = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [CSEL_W-1:0] coarse_sel,
  input logic [FSEL_W-1:0] fine_sel,
  input logic              tick_o
);

  function automatic logic [CNT_W-1:0] period(input logic [CSEL_W-1:0] c,
                                              input logic [FSEL_W-1:0] f);
    logic [CNT_W-1:0] r;
    r = (c == '0) ? CNT_W'(16) : (CNT_W'(32) << c);
    period = r * (CNT_W'(f) + 1'b1);
  endfunction

  logic [CNT_W-1:0]  gap;
  logic [CNT_W-1:0]  exp_p;
  logic [CSEL_W-1:0] prev_c;
  logic [FSEL_W-1:0] prev_f;

  always_ff @(posedge clk) begin
    prev_c <= coarse_sel;
    prev_f <= fine_sel;
    if (rst) begin
      gap   <= '0;
      exp_p <= period(coarse_sel, fine_sel);
    end else begin
      if (tick_o)           gap <= CNT_W'(1);
      else if (~&gap)       gap <= gap + 1'b1;
      if (tick_o)           exp_p <= period(prev_c, prev_f);
    end
  end

  // R4: strobe is one cycle wide
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R7: reset forces the strobe low
  a_r7_reset_quiet: assert property (@(posedge clk)
    rst |=> !tick_o);

  // R3 / R6: a strobe lands exactly one period after the last one or reset
  a_r3_exact_period: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (gap == exp_p));

  // R5: the strobe is never late
  a_r5_not_late: assert property (@(posedge clk) disable iff (rst)
    (gap >= exp_p) |-> tick_o);

endmodule

bind dclk_prescaler dpre_chk #(
  .CSEL_W (CSEL_W),
  .FSEL_W (FSEL_W)
) u_chk (
  .clk        (clk_dsp),
  .rst        (rst),
  .coarse_sel (coarse_sel),
  .fine_sel   (fine_sel),
  .tick_o     (tick_o)
);

// File: tb/dclk_prescaler_test.sv
`timescale 1ns/1ps
module dclk_prescaler_test;

  logic       clk_sys = 1'b0;
  logic       clk_ext = 1'b0;
  logic       rst = 1'b1;
  logic       src_sel = 1'b0;
  logic [2:0] coarse_sel = '0;
  logic [2:0] fine_sel = '0;
  logic       tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4  clk_sys = ~clk_sys;   // 125 MHz
  always #10 clk_ext = ~clk_ext;

  dclk_prescaler uut (
    .clk_sys    (clk_sys),
    .clk_ext    (clk_ext),
    .rst        (rst),
    .src_sel    (src_sel),
    .coarse_sel (coarse_sel),
    .fine_sel   (fine_sel),
    .tick_o     (tick_o)
  );

  // coarse ratio from the R2 code list
  function automatic int ratio_of(input int c);
    case (c)
      0: ratio_of = 16;
      1: ratio_of = 64;
      2: ratio_of = 128;
      3: ratio_of = 256;
      4: ratio_of = 512;
      5: ratio_of = 1024;
      6: ratio_of = 2048;
      default: ratio_of = 4096;
    endcase
  endfunction

  // {coarse, fine}
  localparam int NVEC = 10;
  localparam logic [5:0] VEC [NVEC] = '{
    {3'd0, 3'd0}, {3'd1, 3'd0}, {3'd2, 3'd1}, {3'd3, 3'd2}, {3'd4, 3'd3},
    {3'd5, 3'd0}, {3'd6, 3'd1}, {3'd7, 3'd0}, {3'd0, 3'd7}, {3'd1, 3'd4}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge_pair(input bit ext);
    if (ext) begin @(posedge clk_ext); @(negedge clk_ext); end
    else     begin @(posedge clk_sys); @(negedge clk_sys); end
  endtask

  task automatic do_reset(input bit ext, input int c, input int f);
    if (ext) @(negedge clk_ext); else @(negedge clk_sys);
    rst = 1'b1;
    coarse_sel = 3'(c);
    fine_sel = 3'(f);
    for (int i = 0; i < 3; i++) edge_pair(ext);
    rst = 1'b0;
  endtask

  task automatic wait_tick(input bit ext, output int n);
    n = 0;
    do begin
      edge_pair(ext);
      n++;
    end while (!tick_o && n < 70000);
  endtask

  int n, n2, p;

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    do_reset(1'b0, 0, 0);
    rst = 1'b1;
    edge_pair(1'b0);
    check("R7 tick low in reset", int'(tick_o), 0);
    rst = 1'b0;

    // R2 R3 R5: table of code pairs
    for (int v = 0; v < NVEC; v++) begin
      p = ratio_of(int'(VEC[v][5:3])) * (int'(VEC[v][2:0]) + 1);
      do_reset(1'b0, int'(VEC[v][5:3]), int'(VEC[v][2:0]));
      wait_tick(1'b0, n);
      check("R5 first strobe delay (R2 R3)", n, p);
      edge_pair(1'b0);
      check("R4 strobe one cycle", int'(tick_o), 0);
      wait_tick(1'b0, n);
      check("R3 steady period (R2)", n + 1, p);
    end

    // R8: largest setting
    do_reset(1'b0, 7, 7);
    wait_tick(1'b0, n);
    check("R8 max first period", n, 32768);
    wait_tick(1'b0, n);
    check("R8 max steady period", n, 32768);

    // R6: mid-period code change
    do_reset(1'b0, 0, 0);
    wait_tick(1'b0, n);
    check("R6 baseline period", n, 16);
    for (int i = 0; i < 5; i++) edge_pair(1'b0);
    coarse_sel = 3'd1;
    fine_sel = 3'd1;
    wait_tick(1'b0, n2);
    check("R6 current period unchanged", n2 + 5, 16);
    wait_tick(1'b0, n);
    check("R6 next period uses new codes", n, 128);

    // R7: reset mid count restarts the period
    do_reset(1'b0, 2, 0);
    for (int i = 0; i < 50; i++) edge_pair(1'b0);
    rst = 1'b1;
    edge_pair(1'b0);
    check("R7 tick low after mid reset", int'(tick_o), 0);
    edge_pair(1'b0);
    rst = 1'b0;
    wait_tick(1'b0, n);
    check("R7 full period after mid reset", n, 128);

    // R1: external clock source
    src_sel = 1'b1;
    do_reset(1'b1, 0, 1);
    wait_tick(1'b1, n);
    check("R1 external first period", n, 32);
    wait_tick(1'b1, n);
    check("R1 external steady period", n, 32);
    src_sel = 1'b0;
    do_reset(1'b0, 0, 1);
    wait_tick(1'b0, n);
    check("R1 back on system clock", n, 32);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule